// File: doc/BRIEF.md
# Edge-Acknowledged Interrupt Control Register

This block is the 16-bit control register of a sound-processor board, extended with the logic that keeps the board's four interrupt request lines pending. Software writes the whole register at once. Four of its bits act as interrupt enables while they are 1. When a write takes one of them from 1 to 0, the interrupt on that line is acknowledged.

Each line has a pending flag. The line for level 6 is fed by the rising edge of the ATA drive interrupt input. The lines for levels 1, 2 and 4 are fed by generic one-cycle request pulses from other sources. A request is taken only while its enable bit is 1. A single write acknowledges no more than one line, picked by a fixed order, and the written value is stored as it is in every case. The pending flags and an encoded highest level go to the processor's interrupt inputs.

Top module: `snd_irq_ctl`

## Requirements
- R1: Control bits 7, 8, 9 and 10 belong to interrupt levels 1, 2, 4 and 6. Their pending flags appear on `pend_o[0]`, `pend_o[1]`, `pend_o[2]` and `pend_o[3]`.
- R2: A write that changes a control bit from 1 to 0 clears that line's pending flag at the clock edge where the write is taken.
- R3: A single write clears at most one pending flag. Falling control bits are examined in the order bit 7, bit 8, bit 9, bit 10. Only the first falling bit in that order clears its flag; the flags of later falling bits stay set.
- R4: On every write, all 16 bits of `wr_data` become the new `ctrl_o` value at the next clock edge, whether or not a flag was cleared.
- R5: A rising edge on `ata_irq_i` sets `pend_o[3]` only if control bit 10 held 1 before that edge. An input that stays high does not set the flag again.
- R6: A pulse on `req_i[0]`, `req_i[1]` or `req_i[2]` sets the pending flag for level 1, 2 or 4 only when control bit 7, 8 or 9 respectively held 1. With the enable at 0, the pulse leaves the flag unchanged.
- R7: `irq_lvl_o` gives the highest pending level as a binary number (6, 4, 2 or 1). It is 0 when no flag is pending.
- R8: While `rst_n` is low, `ctrl_o`, `pend_o` and `irq_lvl_o` are all zero.
- R9: When an acknowledge and a request reach the same line in the same cycle, the acknowledge wins and the flag ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Value to write |
| ata_irq_i | input | 1 | ATA drive interrupt level |
| req_i | input | 3 | Request pulses for levels 1, 2, 4 |
| ctrl_o | output | 16 | Current register contents |
| pend_o | output | 4 | Pending flags for levels 1, 2, 4, 6 |
| irq_lvl_o | output | 3 | Highest pending level, 0 if none |

## Verification
A pending flag stuck in the wrong state shows up on `pend_o` and `irq_lvl_o` one clock after the write or request that should have changed it. The bench compares both outputs against its model every cycle, so such an error is seen within one cycle. A wrong acknowledge order only becomes visible when several enable bits fall in the same write. Directed writes therefore drop all four bits at once and then check which flags remain. Random writes mix requests, ATA edges and enable changes, so that a stale edge detector or an enable gate that reads the wrong bit changes `pend_o` within a few cycles.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  localparam int CTRL_W   = 16;
  localparam int N_LINES  = 4;
  localparam int LINE_LSB = 7;
  localparam int LVL_W    = 3;

  function automatic logic [LVL_W-1:0] lvl_code(input int idx);
    case (idx)
      0:       lvl_code = LVL_W'(1);
      1:       lvl_code = LVL_W'(2);
      2:       lvl_code = LVL_W'(4);
      default: lvl_code = LVL_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/irq_ack_pick.sv
module irq_ack_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] falling_i,
  output logic [N-1:0] clr_o
);
  // lowest index wins: isolate least significant set bit
  always_comb begin
    clr_o = falling_i & (~falling_i + N'(1));
  end
endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  always_comb begin
    pend_d = pend_o;
    if (clr_i)      pend_d = 1'b0;
    else if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
  import snd_irq_pkg::*;
#(
  parameter int N = N_LINES
) (
  input  logic [N-1:0]     pend_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) lvl_o = lvl_code(i);
    end
  end
endmodule

// File: rtl/snd_irq_ctl.sv
module snd_irq_ctl
  import snd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ata_irq_i,
  input  logic [N_LINES-2:0] req_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [N_LINES-1:0] pend_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic               ata_q, ata_d;
  logic [N_LINES-1:0] line_en, falling, clr, raw_req, set_req;

  assign line_en = ctrl_q[LINE_LSB +: N_LINES];

  always_comb begin
    ctrl_d  = wr_en ? wr_data : ctrl_q;
    ata_d   = ata_irq_i;
    falling = wr_en ? (line_en & ~wr_data[LINE_LSB +: N_LINES]) : '0;
    raw_req = {ata_irq_i & ~ata_q, req_i};
    set_req = raw_req & line_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ata_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ata_q  <= ata_d;
    end
  end

  irq_ack_pick #(.N(N_LINES)) u_pick (.falling_i(falling), .clr_o(clr));

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line u_line (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_req[g]), .clr_i(clr[g]),
      .pend_o(pend_o[g])
    );
  end

  irq_lvl_enc #(.N(N_LINES)) u_enc (.pend_i(pend_o), .lvl_o(irq_lvl_o));

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/snd_irq_ctl_chk.sv
module snd_irq_ctl_chk
  import snd_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [N_LINES-1:0] pend_o,
  input logic [LVL_W-1:0]  irq_lvl_o
);
  p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_o == $past(wr_data)));

  p_one_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones($past(pend_o) & ~pend_o) <= 1));

  p_no_ack_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(pend_o) & ~pend_o) == '0));

  p_ata_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o[N_LINES-1]) |-> $past(ctrl_o[LINE_LSB+N_LINES-1]));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |-> (irq_lvl_o == '0));

  p_top_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[N_LINES-1] |-> (irq_lvl_o == LVL_W'(6)));
endmodule

bind snd_irq_ctl snd_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ctrl_o(ctrl_o), .pend_o(pend_o), .irq_lvl_o(irq_lvl_o)
);

// File: tb/snd_irq_ctl_tb.sv
module snd_irq_ctl_tb;
  logic        clk, rst_n, wr_en, ata;
  logic [15:0] wr_data;
  logic [2:0]  req;
  logic [15:0] ctrl_o;
  logic [3:0]  pend_o;
  logic [2:0]  lvl_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_ctrl;
  logic [3:0]  m_pend;
  logic        m_ata;

  snd_irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ata_irq_i(ata), .req_i(req), .ctrl_o(ctrl_o), .pend_o(pend_o),
    .irq_lvl_o(lvl_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [2:0] exp_lvl(input logic [3:0] p);
    if (p[3]) return 3'd6;
    if (p[2]) return 3'd4;
    if (p[1]) return 3'd2;
    if (p[0]) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic w, input logic [15:0] d, input logic a, input logic [2:0] r);
    logic [3:0] en, fall, clr, set;
    en   = m_ctrl[10:7];
    fall = w ? (en & ~d[10:7]) : 4'b0;
    clr  = 4'b0;
    for (int i = 0; i < 4; i++)
      if (fall[i] && clr == 4'b0) clr[i] = 1'b1;
    set = {a & ~m_ata, r} & en;
    for (int i = 0; i < 4; i++)
      m_pend[i] = clr[i] ? 1'b0 : (m_pend[i] | set[i]);
    if (w) m_ctrl = d;
    m_ata = a;
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic a,
                      input logic [2:0] r, input string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; ata = a; req = r;
    @(posedge clk); #1;
    model(w, d, a, r);
    wr_en = 0; req = 0;
    chk({tag, " ctrl R4"}, 32'(ctrl_o), 32'(m_ctrl));
    chk({tag, " pend"}, 32'(pend_o), 32'(m_pend));
    chk({tag, " level R7"}, 32'(lvl_o), 32'(exp_lvl(m_pend)));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 0; wr_en = 0; wr_data = 0; ata = 0; req = 0;
    m_ctrl = 0; m_pend = 0; m_ata = 0;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset ctrl", 32'(ctrl_o), 0);
    chk("R8 reset pend", 32'(pend_o), 0);
    chk("R8 reset level", 32'(lvl_o), 0);
    @(negedge clk); rst_n = 1;

    // R6: requests with enables off are ignored
    step(0, 16'h0, 0, 3'b111, "R6 gated off");
    chk("R6 nothing pending", 32'(pend_o), 0);
    // enable all four, stored whole (R4)
    step(1, 16'hA5F5 | 16'h0780, 0, 3'b000, "R4 full store");
    step(0, 16'h0, 0, 3'b111, "R6 R1 set 1,2,4");
    chk("R1 lines 1,2,4", 32'(pend_o), 32'h7);
    step(0, 16'h0, 1, 3'b000, "R5 ata rise");
    chk("R5 level6 set", 32'(pend_o), 32'hF);
    chk("R7 level 6", 32'(lvl_o), 6);
    // R3: drop all four enables in one write: only bit 7 line cleared
    step(1, 16'h0000, 1, 3'b000, "R3 multi fall");
    chk("R3 first only", 32'(pend_o), 32'hE);
    step(1, 16'h0000, 1, 3'b000, "R3 no fall");
    chk("R3 others stay", 32'(pend_o), 32'hE);
    // re-enable, drop bit 9 only (R2)
    step(1, 16'h0780, 1, 3'b000, "R2 reenable");
    step(1, 16'h0580, 1, 3'b000, "R2 drop bit9");
    chk("R2 level4 cleared", 32'(pend_o), 32'hA);
    // R5: held-high ATA does not re-set after ack
    step(1, 16'h0180, 1, 3'b000, "R5 ack level6");
    chk("R5 cleared", 32'(pend_o), 32'h2);
    step(1, 16'h0580, 1, 3'b000, "R5 reenable held");
    step(0, 16'h0, 1, 3'b000, "R5 held high");
    chk("R5 no reset from level", 32'(pend_o), 32'h2);
    step(0, 16'h0, 0, 3'b000, "R5 low");
    step(0, 16'h0, 1, 3'b000, "R5 new edge");
    chk("R5 new edge sets", 32'(pend_o), 32'hA);
    // R5: edge with bit10 off is ignored
    step(1, 16'h0180, 0, 3'b000, "R5 disable");
    step(0, 16'h0, 1, 3'b000, "R5 gated edge");
    chk("R5 gated", 32'(pend_o[3]), 0);
    // R9: ack and request on same line same cycle
    step(1, 16'h0080, 0, 3'b010, "R9 ack vs req");
    chk("R9 ack wins", 32'(pend_o[1]), 0);
    chk("R7 level 0", 32'(lvl_o), 0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [15:0] d;
      logic        w;
      d = 16'($urandom);
      w = ($urandom % 4) == 0;
      step(w, d, 1'($urandom % 2), 3'($urandom), "R1/R2/R3/R5/R6/R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule